// File: doc/BRIEF.md
# Interrupt Test Generator

A small slave on a synchronous register bus that lets test software drive the two processor interrupt lines: a normal interrupt request (`irq`) and a fast interrupt request (`fiq`). Software can raise either line at once, or arm a per-line countdown that raises it a chosen number of clock cycles after the arming write. A raised line is a level that stays high until software writes the clear register.

The block decodes four word addresses in a 16-byte window starting at `BASE_ADDR`. It only claims write cycles. A cycle it does not claim leaves `bus_hit` low, so a different slave on the same bus can answer it. It has no readable state. Each line has its own down-counter, so a delayed `irq` and a delayed `fiq` can be pending together.

Top module: `irq_test_gen`

## Requirements
- R1: The block decodes exactly four word addresses: BASE+0x0 (immediate raise), BASE+0x4 (`irq` delay), BASE+0x8 (`fiq` delay) and BASE+0xC (clear). Unaligned or out-of-window addresses are not decoded.
- R2: Writing data 1 to BASE+0x0 raises `irq` at the clock edge that captures the write. Writing data 2 raises `fiq` at that edge.
- R3: Writing D to BASE+0x4 raises `irq` at the D-th clock edge after the edge that captures the write. D=0 raises it at the capturing edge itself.
- R4: Writing D to BASE+0x8 raises `fiq` with the same timing rule as R3.
- R5: Writing data 1 to BASE+0xC lowers `irq` at the capturing edge. Writing data 2 lowers `fiq` at that edge.
- R6: Any data other than 1 or 2 written to BASE+0x0 or BASE+0xC leaves both lines unchanged, but `bus_hit` is still high for that write.
- R7: `bus_hit` is high only while `bus_we` is high and the address is one of the four decoded words. A cycle with `bus_we` low (a read) or with another address has no effect on either line.
- R8: A raised line stays high, including across further raise writes, until a clear write for that line.
- R9: The `irq` and `fiq` countdowns run independently and can both be pending at the same time.
- R10: A new write to a delay register restarts that line's countdown from the new value. The earlier pending event is discarded.
- R11: When a clear write for a line is captured at the same edge on which that line's countdown expires, the clear wins and the line stays low.
- R12: Reset (`rst_n` low) lowers both lines and cancels any pending countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the bus cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_hit | output | 1 | High when this block claims the current write |
| irq | output | 1 | Normal interrupt request level |
| fiq | output | 1 | Fast interrupt request level |

## Verification
The bench counts edges from each arming write and checks the cycle just before expiry and the expiry cycle itself. A design off by one register in the countdown path would raise the line a cycle early or late. The bench re-arms a running countdown with a longer delay: a design that keeps the old event would raise the line at the first deadline. It also aligns a clear write with an expiry edge: a design that gives the set priority would leave the line high. Other cases covered are out-of-window addresses, read cycles, unused data codes, and a reset while a countdown is pending. In each of these a design that decodes too loosely or forgets to cancel the countdown would raise a line it should not.

// File: rtl/irqgen_pkg.sv
package irqgen_pkg;

    localparam int NUM_LINES = 2;
    localparam int LINE_IRQ  = 0;
    localparam int LINE_FIQ  = 1;

    // word select inside the 16-byte window, bits [3:2] of the address
    typedef enum logic [1:0] {
        SEL_RAISE   = 2'd0,
        SEL_IRQ_DLY = 2'd1,
        SEL_FIQ_DLY = 2'd2,
        SEL_CLEAR   = 2'd3
    } word_sel_e;

    // per-line actions decoded from one bus write
    typedef struct packed {
        logic [NUM_LINES-1:0] raise;
        logic [NUM_LINES-1:0] lower;
        logic [NUM_LINES-1:0] arm;
    } line_cmd_t;

endpackage

// File: rtl/irqgen_decode.sv
module irqgen_decode
    import irqgen_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              DATA_W    = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0020_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic              hit,
    output line_cmd_t         cmd
);

    localparam int WIN_LSB = 4;

    logic      in_window;
    word_sel_e sel;

    always_comb begin
        in_window = (bus_addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB])
                    && (bus_addr[1:0] == 2'b00);
        sel       = word_sel_e'(bus_addr[3:2]);
        hit       = bus_we && in_window;
    end

    // data code n+1 selects line n on the raise and clear words
    for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
        logic code_match;
        always_comb begin
            code_match       = (bus_wdata == DATA_W'(ln + 1));
            cmd.raise[ln]    = hit && (sel == SEL_RAISE) && code_match;
            cmd.lower[ln]    = hit && (sel == SEL_CLEAR) && code_match;
        end
    end

    always_comb begin
        cmd.arm           = '0;
        cmd.arm[LINE_IRQ] = hit && (sel == SEL_IRQ_DLY);
        cmd.arm[LINE_FIQ] = hit && (sel == SEL_FIQ_DLY);
    end

    AST_HIT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |-> !hit); // R7

    AST_SINGLE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cmd.raise, cmd.lower, cmd.arm}) <= 1); // R1

endmodule

// File: rtl/irqgen_countdown.sv
module irqgen_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [CNT_W-1:0] arm_val,
    output logic             expire
);

    typedef struct packed {
        logic             running;
        logic [CNT_W-1:0] remain;
    } cd_state_t;

    cd_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (arm) begin
            // a new arm replaces whatever was pending
            if (arm_val == '0) begin
                expire       = 1'b1;
                st_d.running = 1'b0;
            end else begin
                st_d.running = 1'b1;
                st_d.remain  = arm_val - CNT_W'(1);
            end
        end else if (st_q.running) begin
            if (st_q.remain == '0) begin
                expire       = 1'b1;
                st_d.running = 1'b0;
            end else begin
                st_d.remain  = st_q.remain - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.running && st_q.remain != '0 && !arm)
        |=> (st_q.running && st_q.remain == $past(st_q.remain) - CNT_W'(1))); // R3

    AST_EXPIRY_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.running && st_q.remain == '0 && !arm) |=> !st_q.running); // R3

    AST_REARM_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && arm_val != '0)
        |=> (st_q.running && st_q.remain == $past(arm_val) - CNT_W'(1))); // R10

endmodule

// File: rtl/irqgen_level.sv
module irqgen_level (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic lvl
);

    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (set) lvl_d = 1'b1;
        if (clr) lvl_d = 1'b0;   // clear overrides any set in the same cycle
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign lvl = lvl_q;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !lvl); // R11

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (set && !clr) |=> lvl); // R2

    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl && !clr) |=> lvl); // R8

endmodule

// File: rtl/irq_test_gen.sv
module irq_test_gen
    import irqgen_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter int                DATA_W    = 32,
    parameter int                CNT_W     = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0020_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic              bus_hit,
    output logic              irq,
    output logic              fiq
);

    localparam int DLY_W = (CNT_W < DATA_W) ? CNT_W : DATA_W;

    line_cmd_t            cmd;
    logic [NUM_LINES-1:0] expire;
    logic [NUM_LINES-1:0] line_set;
    logic [NUM_LINES-1:0] line_lvl;
    logic [CNT_W-1:0]     dly_val;

    always_comb begin
        dly_val = '0;
        dly_val[DLY_W-1:0] = bus_wdata[DLY_W-1:0];
    end

    irqgen_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .hit       (bus_hit),
        .cmd       (cmd)
    );

    for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
        irqgen_countdown #(
            .CNT_W   (CNT_W)
        ) u_cd (
            .clk     (clk),
            .rst_n   (rst_n),
            .arm     (cmd.arm[ln]),
            .arm_val (dly_val),
            .expire  (expire[ln])
        );

        always_comb line_set[ln] = cmd.raise[ln] || expire[ln];

        irqgen_level u_lvl (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (line_set[ln]),
            .clr   (cmd.lower[ln]),
            .lvl   (line_lvl[ln])
        );
    end

    assign irq = line_lvl[LINE_IRQ];
    assign fiq = line_lvl[LINE_FIQ];

    AST_UNCLAIMED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_hit && expire == '0) |=> ($stable(irq) && $stable(fiq))); // R7

    AST_IRQ_ARM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd.arm[LINE_IRQ] && dly_val == '0 && !cmd.lower[LINE_IRQ]) |=> irq); // R3

endmodule

// File: tb/sim_irq_test_gen.sv
module sim_irq_test_gen;

    localparam logic [31:0] BASE = 32'h0020_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_hit, irq, fiq;

    int cyc = 0;
    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        int    at;
        logic  e_irq;
        logic  e_fiq;
        string tag;
    } sb_item_t;

    sb_item_t sbq[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    irq_test_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_hit   (bus_hit),
        .irq       (irq),
        .fiq       (fiq)
    );

    // monitor: pops expectations as their cycle comes up
    always begin
        @(negedge clk);
        #2;
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            sb_item_t it;
            it = sbq.pop_front();
            total++;
            if (it.at != cyc || irq !== it.e_irq || fiq !== it.e_fiq) begin
                bad++;
                $display("FAIL %s cyc=%0d(due %0d) irq/fiq actual=%b%b expected=%b%b",
                         it.tag, cyc, it.at, irq, fiq, it.e_irq, it.e_fiq);
            end
        end
    end

    task automatic expect_at(input int at, input logic ei, input logic ef, input string tag);
        sbq.push_back('{at, ei, ef, tag});
    endtask

    task automatic check_hit(input logic exp_hit, input string tag);
        total++;
        if (bus_hit !== exp_hit) begin
            bad++;
            $display("FAIL %s bus_hit actual=%b expected=%b", tag, bus_hit, exp_hit);
        end
    endtask

    // called at a falling edge; returns the cycle number of the capturing edge
    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic exp_hit,
                      input string tag, output int e0);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        e0 = cyc + 1;
        #1;
        check_hit(exp_hit, tag);
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a, input logic [31:0] d, input string tag);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b0;
        #1;
        check_hit(1'b0, tag);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int a, b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        expect_at(cyc, 1'b0, 1'b0, "R12 reset state");
        probe(BASE, 32'd1, "R7 read cycle");
        expect_at(cyc, 1'b0, 1'b0, "R7 read no effect");

        // R2 immediate raise
        wr(BASE, 32'd1, 1'b1, "R2", a);  expect_at(a, 1'b1, 1'b0, "R2 irq raise");
        wr(BASE, 32'd2, 1'b1, "R2", a);  expect_at(a, 1'b1, 1'b1, "R2 fiq raise");
        // R6 unused codes
        wr(BASE, 32'd7, 1'b1, "R6", a);          expect_at(a, 1'b1, 1'b1, "R6 raise code 7");
        wr(BASE + 32'hC, 32'd3, 1'b1, "R6", a);  expect_at(a, 1'b1, 1'b1, "R6 clear code 3");
        // R5 clear
        wr(BASE + 32'hC, 32'd1, 1'b1, "R5", a);  expect_at(a, 1'b0, 1'b1, "R5 irq clear");
        wr(BASE + 32'hC, 32'd2, 1'b1, "R5", a);  expect_at(a, 1'b0, 1'b0, "R5 fiq clear");

        // R7 / R1 undecoded addresses
        wr(BASE + 32'h10, 32'd1, 1'b0, "R7", a);   expect_at(a, 1'b0, 1'b0, "R7 past window");
        wr(32'h0030_0000, 32'd2, 1'b0, "R7", a);   expect_at(a, 1'b0, 1'b0, "R7 other base");
        wr(BASE + 32'h1, 32'd1, 1'b0, "R1", a);    expect_at(a, 1'b0, 1'b0, "R1 unaligned");

        // R3 delayed irq, then R8 hold
        wr(BASE + 32'h4, 32'd5, 1'b1, "R3", a);
        expect_at(a + 3, 1'b0, 1'b0, "R3 counting");
        expect_at(a + 4, 1'b0, 1'b0, "R3 one before");
        expect_at(a + 5, 1'b1, 1'b0, "R3 expiry");
        idle(12);
        expect_at(cyc, 1'b1, 1'b0, "R8 holds");
        wr(BASE, 32'd1, 1'b1, "R8", a);            expect_at(a, 1'b1, 1'b0, "R8 re-raise");
        wr(BASE + 32'hC, 32'd1, 1'b1, "R5", a);    expect_at(a, 1'b0, 1'b0, "R5 irq clear");

        // R4 delayed fiq, zero and nonzero
        wr(BASE + 32'h8, 32'd0, 1'b1, "R4", a);    expect_at(a, 1'b0, 1'b1, "R4 zero delay");
        wr(BASE + 32'hC, 32'd2, 1'b1, "R5", a);    expect_at(a, 1'b0, 1'b0, "R5 fiq clear");
        wr(BASE + 32'h8, 32'd3, 1'b1, "R4", a);
        expect_at(a + 2, 1'b0, 1'b0, "R4 one before");
        expect_at(a + 3, 1'b0, 1'b1, "R4 expiry");
        idle(5);
        wr(BASE + 32'hC, 32'd2, 1'b1, "R5", a);    expect_at(a, 1'b0, 1'b0, "R5 fiq clear");

        // R9 both pending
        wr(BASE + 32'h4, 32'd6, 1'b1, "R9", a);
        wr(BASE + 32'h8, 32'd2, 1'b1, "R9", b);
        expect_at(b + 1, 1'b0, 1'b0, "R9 fiq before");
        expect_at(b + 2, 1'b0, 1'b1, "R9 fiq fires");
        expect_at(a + 5, 1'b0, 1'b1, "R9 irq before");
        expect_at(a + 6, 1'b1, 1'b1, "R9 irq fires");
        idle(8);
        wr(BASE + 32'hC, 32'd1, 1'b1, "R5", a);    expect_at(a, 1'b0, 1'b1, "R5 irq clear");
        wr(BASE + 32'hC, 32'd2, 1'b1, "R5", a);    expect_at(a, 1'b0, 1'b0, "R5 fiq clear");

        // R10 restart drops earlier event
        wr(BASE + 32'h4, 32'd4, 1'b1, "R10", a);
        idle(1);
        wr(BASE + 32'h4, 32'd8, 1'b1, "R10", b);
        expect_at(a + 4, 1'b0, 1'b0, "R10 old deadline dropped");
        expect_at(b + 7, 1'b0, 1'b0, "R10 one before new");
        expect_at(b + 8, 1'b1, 1'b0, "R10 new deadline");
        idle(10);
        wr(BASE + 32'hC, 32'd1, 1'b1, "R5", a);    expect_at(a, 1'b0, 1'b0, "R5 irq clear");

        // R11 clear coincides with expiry
        wr(BASE + 32'h4, 32'd3, 1'b1, "R11", a);
        expect_at(a + 2, 1'b0, 1'b0, "R11 before");
        expect_at(a + 3, 1'b0, 1'b0, "R11 clear wins");
        expect_at(a + 4, 1'b0, 1'b0, "R11 stays low");
        idle(2);
        wr(BASE + 32'hC, 32'd1, 1'b1, "R11", b);
        idle(4);

        // R12 reset cancels pending countdown
        wr(BASE + 32'h4, 32'd5, 1'b1, "R12", a);
        wr(BASE, 32'd2, 1'b1, "R12", b);           expect_at(b, 1'b0, 1'b1, "R12 fiq up");
        idle(1);
        rst_n = 1'b0;
        expect_at(cyc, 1'b0, 1'b0, "R12 reset lowers");
        idle(2);
        rst_n = 1'b1;
        expect_at(a + 6, 1'b0, 1'b0, "R12 pending cancelled");
        expect_at(a + 10, 1'b0, 1'b0, "R12 still low");
        idle(14);

        total++;
        if (sbq.size() != 0) begin
            bad++;
            $display("FAIL R1-queue leftover actual=%0d expected=0", sbq.size());
        end
        finished = 1;
        summary();
        $finish;
    end

endmodule